// File: doc/BRIEF.md
# Special Register Access Checker

This block sits beside the execute stage of a processor core and rules on each request to move a value to or from a special-purpose register. Each request carries a 10-bit register number, a direction flag and the current privilege state. From these the block decides the outcome of the access. It may perform the access, which for a read sets the destination write enable and picks a source on the slow-read multiplexer. It may reduce the access to a no-op, read back zero, or raise a hypervisor emulation assistance trap. The register storage itself is held elsewhere. This block only produces the control signals that steer it.

The sets of register numbers are elaboration-time parameters. These sets are: numbers that always trap, reserved numbers that act as no-ops, read-as-zero numbers, two logging registers that share one selector code, slow registers that each have their own selector code, and ordinary fast registers. Any number that is in none of these sets is undefined. In hypervisor state an undefined number traps or acts as a no-op, depending on an emulate-virtualisation control bit. In user state it always traps. The block also masks the pending external interrupt with an interrupt-disable control bit, and that mask applies only in hypervisor state.

All outputs are registered, so the verdict on a request is presented one clock after the request.

Top module: `spr_access_checker`

## Requirements
- R1: An access, read or write, to register number 0, 4, 5 or 6 raises the trap output with the write enable low and the selector 0, in either privilege state.
- R2: In hypervisor state, an access to an undefined number raises the trap when the emulate-virtualisation bit is 1. When that bit is 0 the access is a no-op, with trap low, write enable low and selector 0.
- R3: In user state, an access to an undefined number raises the trap, whatever the value of the emulate-virtualisation bit.
- R4: A read of a fast register (defaults 1, 8, 9, 26) sets the write enable with selector 0. A read of a slow register sets the write enable with that register's own selector (defaults: 268 gives 3, 269 gives 4).
- R5: A read of a read-as-zero register (defaults 200 to 203) sets the write enable with selector 1. A write to one of these registers produces no trap and no write enable.
- R6: The two logging registers (defaults 1020 and 1021) both read through selector 2, with the write enable set.
- R7: A read of a reserved no-op number (defaults 808 to 811) leaves the write enable low and the trap low, in either privilege state.
- R8: A write request that does not trap never sets the destination write enable and leaves the selector at 0.
- R9: The external-interrupt valid output equals the pending interrupt input, except in hypervisor state with the disable bit set, where it is forced low. The disable bit has no effect in user state.
- R10: The trap output and the write enable are never high in the same cycle.
- R11: After reset, and in any cycle that follows a cycle without a request, the write enable, trap and selector are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A register move request is present |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_num | input | 10 | Special register number |
| hv_mode | input | 1 | 1 = hypervisor (privileged) state, 0 = user state |
| emu_virt | input | 1 | Undefined numbers trap in hypervisor state when 1 |
| irq_disable | input | 1 | Blocks external interrupts in hypervisor state |
| ext_irq_req | input | 1 | External interrupt pending |
| gpr_we | output | 1 | Destination register write enable |
| slow_sel | output | 4 | Slow-read multiplexer selector |
| emu_trap | output | 1 | Hypervisor emulation assistance trap request |
| ext_irq_valid | output | 1 | External interrupt may be taken |

## Verification
Every result (write enable, selector, trap and interrupt valid) passes through exactly one register. Each verdict is therefore due on the first rising edge after the request is applied. The bench drives each vector at a falling edge and samples the outputs at the next falling edge. That point lies half a period after the edge that captured the verdict and before the next request can take effect. The idle and reset checks follow the same one-edge rule: the outputs are read at the falling edge after the idle or reset cycle.

// File: rtl/spr_chk_pkg.sv
package spr_chk_pkg;
  localparam int NUM_W = 10;
  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] SEL_FAST = 4'd0;
  localparam logic [SEL_W-1:0] SEL_ZERO = 4'd1;
  localparam logic [SEL_W-1:0] SEL_LOG  = 4'd2;

  typedef enum logic [2:0] {
    CLS_TRAP,
    CLS_NOP,
    CLS_ZERO,
    CLS_LOG,
    CLS_SLOW,
    CLS_FAST,
    CLS_UNDEF
  } spr_class_e;

  typedef struct packed {
    logic             we;
    logic             trap;
    logic [SEL_W-1:0] sel;
  } spr_verdict_t;
endpackage

// File: rtl/spr_set_match.sv
module spr_set_match #(
  parameter int N = 4,
  parameter int W = 10,
  parameter logic [N*W-1:0] LIST = '0
) (
  input  logic [W-1:0] num,
  output logic [N-1:0] hit_vec,
  output logic         hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = (num == LIST[i*W +: W]);
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/spr_classifier.sv
module spr_classifier
  import spr_chk_pkg::*;
#(
  parameter int N_TRAP = 4,
  parameter logic [N_TRAP*NUM_W-1:0] TRAP_LIST = {10'd6, 10'd5, 10'd4, 10'd0},
  parameter int N_NOP = 4,
  parameter logic [N_NOP*NUM_W-1:0] NOP_LIST = {10'd811, 10'd810, 10'd809, 10'd808},
  parameter int N_ZERO = 4,
  parameter logic [N_ZERO*NUM_W-1:0] ZERO_LIST = {10'd203, 10'd202, 10'd201, 10'd200},
  parameter logic [2*NUM_W-1:0] LOG_LIST = {10'd1021, 10'd1020},
  parameter int N_SLOW = 2,
  parameter logic [N_SLOW*NUM_W-1:0] SLOW_LIST = {10'd269, 10'd268},
  parameter logic [N_SLOW*SEL_W-1:0] SLOW_SEL = {4'd4, 4'd3},
  parameter int N_FAST = 4,
  parameter logic [N_FAST*NUM_W-1:0] FAST_LIST = {10'd26, 10'd9, 10'd8, 10'd1}
) (
  input  logic [NUM_W-1:0] num,
  input  logic             is_write,
  input  logic             hv_mode,
  input  logic             emu_virt,
  output spr_class_e       cls,
  output spr_verdict_t     verdict
);
  logic [N_TRAP-1:0] trap_vec;
  logic [N_NOP-1:0]  nop_vec;
  logic [N_ZERO-1:0] zero_vec;
  logic [1:0]        log_vec;
  logic [N_SLOW-1:0] slow_vec;
  logic [N_FAST-1:0] fast_vec;
  logic trap_hit, nop_hit, zero_hit, log_hit, slow_hit, fast_hit;
  logic [SEL_W-1:0] slow_code;

  spr_set_match #(.N(N_TRAP), .W(NUM_W), .LIST(TRAP_LIST)) u_trap (
    .num(num), .hit_vec(trap_vec), .hit(trap_hit));
  spr_set_match #(.N(N_NOP), .W(NUM_W), .LIST(NOP_LIST)) u_nop (
    .num(num), .hit_vec(nop_vec), .hit(nop_hit));
  spr_set_match #(.N(N_ZERO), .W(NUM_W), .LIST(ZERO_LIST)) u_zero (
    .num(num), .hit_vec(zero_vec), .hit(zero_hit));
  spr_set_match #(.N(2), .W(NUM_W), .LIST(LOG_LIST)) u_log (
    .num(num), .hit_vec(log_vec), .hit(log_hit));
  spr_set_match #(.N(N_SLOW), .W(NUM_W), .LIST(SLOW_LIST)) u_slow (
    .num(num), .hit_vec(slow_vec), .hit(slow_hit));
  spr_set_match #(.N(N_FAST), .W(NUM_W), .LIST(FAST_LIST)) u_fast (
    .num(num), .hit_vec(fast_vec), .hit(fast_hit));

  // Only the per-entry slow vector carries information beyond its OR.
  logic unused_vecs;
  assign unused_vecs = ^{trap_vec, nop_vec, zero_vec, log_vec, fast_vec};

  always_comb begin
    slow_code = SEL_FAST;
    for (int i = 0; i < N_SLOW; i++) begin
      if (slow_vec[i]) slow_code = SLOW_SEL[i*SEL_W +: SEL_W];
    end
  end

  always_comb begin
    if (trap_hit)      cls = CLS_TRAP;
    else if (nop_hit)  cls = CLS_NOP;
    else if (zero_hit) cls = CLS_ZERO;
    else if (log_hit)  cls = CLS_LOG;
    else if (slow_hit) cls = CLS_SLOW;
    else if (fast_hit) cls = CLS_FAST;
    else               cls = CLS_UNDEF;
  end

  always_comb begin
    verdict = '0;
    unique case (cls)
      CLS_TRAP:  verdict.trap = 1'b1;
      CLS_NOP:   ;
      CLS_ZERO:  if (!is_write) begin verdict.we = 1'b1; verdict.sel = SEL_ZERO; end
      CLS_LOG:   if (!is_write) begin verdict.we = 1'b1; verdict.sel = SEL_LOG; end
      CLS_SLOW:  if (!is_write) begin verdict.we = 1'b1; verdict.sel = slow_code; end
      CLS_FAST:  if (!is_write) verdict.we = 1'b1;
      CLS_UNDEF: verdict.trap = hv_mode ? emu_virt : 1'b1;
      default:   verdict = '0;
    endcase
  end
endmodule

// File: rtl/spr_irq_gate.sv
module spr_irq_gate (
  input  logic ext_irq_req,
  input  logic hv_mode,
  input  logic irq_disable,
  output logic irq_ok
);
  // The disable bit is honoured only in hypervisor state.
  assign irq_ok = ext_irq_req & ~(irq_disable & hv_mode);
endmodule

// File: rtl/spr_access_checker.sv
module spr_access_checker
  import spr_chk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [NUM_W-1:0] req_num,
  input  logic             hv_mode,
  input  logic             emu_virt,
  input  logic             irq_disable,
  input  logic             ext_irq_req,
  output logic             gpr_we,
  output logic [SEL_W-1:0] slow_sel,
  output logic             emu_trap,
  output logic             ext_irq_valid
);
  spr_class_e   cls;
  spr_verdict_t verdict;
  logic         irq_ok;

  spr_classifier u_cls (
    .num(req_num), .is_write(req_write), .hv_mode(hv_mode),
    .emu_virt(emu_virt), .cls(cls), .verdict(verdict));

  spr_irq_gate u_irq (
    .ext_irq_req(ext_irq_req), .hv_mode(hv_mode),
    .irq_disable(irq_disable), .irq_ok(irq_ok));

  logic unused_cls;
  assign unused_cls = ^cls;

  always_ff @(posedge clk) begin
    if (rst) begin
      gpr_we        <= 1'b0;
      slow_sel      <= '0;
      emu_trap      <= 1'b0;
      ext_irq_valid <= 1'b0;
    end else begin
      gpr_we        <= req_valid & verdict.we;
      slow_sel      <= req_valid ? verdict.sel : '0;
      emu_trap      <= req_valid & verdict.trap;
      ext_irq_valid <= irq_ok;
    end
  end

  a_r10_trap_excl_we: assert property (@(posedge clk) disable iff (rst)
    !(emu_trap && gpr_we));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!gpr_we && !emu_trap && slow_sel == '0));
  a_r8_write_no_we: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (!gpr_we && slow_sel == '0));
  a_r9_user_irq_pass: assert property (@(posedge clk) disable iff (rst)
    (!hv_mode && ext_irq_req) |=> ext_irq_valid);
  a_r9_hv_irq_block: assert property (@(posedge clk) disable iff (rst)
    (hv_mode && irq_disable) |=> !ext_irq_valid);
  a_r5_zero_sel_reads: assert property (@(posedge clk) disable iff (rst)
    (slow_sel == SEL_ZERO) |-> gpr_we);
endmodule

// File: tb/tb_spr_access_checker.sv
`timescale 1ns/1ps
module tb_spr_access_checker;
  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write, hv_mode, emu_virt, irq_disable, ext_irq_req;
  logic [9:0] req_num;
  logic gpr_we, emu_trap, ext_irq_valid;
  logic [3:0] slow_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  spr_access_checker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_num(req_num), .hv_mode(hv_mode), .emu_virt(emu_virt),
    .irq_disable(irq_disable), .ext_irq_req(ext_irq_req),
    .gpr_we(gpr_we), .slow_sel(slow_sel), .emu_trap(emu_trap),
    .ext_irq_valid(ext_irq_valid));

  // Vector: {valid, write, hv, evirt, num[9:0], exp_we, exp_trap, exp_sel[3:0]}
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b0,10'd0,   1'b0,1'b1,4'd0}, // R1 read 0 hv
    {1'b1,1'b1,1'b0,1'b0,10'd5,   1'b0,1'b1,4'd0}, // R1 write 5 user
    {1'b1,1'b0,1'b1,1'b0,10'd6,   1'b0,1'b1,4'd0}, // R1 read 6 hv evirt 0
    {1'b1,1'b0,1'b1,1'b1,10'd300, 1'b0,1'b1,4'd0}, // R2 undefined, evirt 1
    {1'b1,1'b0,1'b1,1'b0,10'd300, 1'b0,1'b0,4'd0}, // R2 undefined read no-op
    {1'b1,1'b1,1'b1,1'b0,10'd300, 1'b0,1'b0,4'd0}, // R2 undefined write no-op
    {1'b1,1'b0,1'b0,1'b0,10'd300, 1'b0,1'b1,4'd0}, // R3 user undefined read
    {1'b1,1'b1,1'b0,1'b1,10'd999, 1'b0,1'b1,4'd0}, // R3 user undefined write
    {1'b1,1'b0,1'b1,1'b0,10'd8,   1'b1,1'b0,4'd0}, // R4 fast read
    {1'b1,1'b0,1'b0,1'b0,10'd268, 1'b1,1'b0,4'd3}, // R4 slow read sel 3
    {1'b1,1'b0,1'b1,1'b1,10'd269, 1'b1,1'b0,4'd4}, // R4 slow read sel 4
    {1'b1,1'b0,1'b1,1'b0,10'd201, 1'b1,1'b0,4'd1}, // R5 read-zero
    {1'b1,1'b1,1'b1,1'b0,10'd203, 1'b0,1'b0,4'd0}, // R5 write ignored
    {1'b1,1'b0,1'b1,1'b0,10'd1020,1'b1,1'b0,4'd2}, // R6 log A
    {1'b1,1'b0,1'b0,1'b0,10'd1021,1'b1,1'b0,4'd2}, // R6 log B
    {1'b1,1'b0,1'b1,1'b1,10'd809, 1'b0,1'b0,4'd0}, // R7 no-op hv
    {1'b1,1'b0,1'b0,1'b0,10'd811, 1'b0,1'b0,4'd0}, // R7 no-op user
    {1'b1,1'b1,1'b1,1'b0,10'd26,  1'b0,1'b0,4'd0}, // R8 fast write
    {1'b1,1'b1,1'b0,1'b0,10'd268, 1'b0,1'b0,4'd0}, // R8 slow write
    {1'b0,1'b0,1'b1,1'b0,10'd8,   1'b0,1'b0,4'd0}  // R11 no request
  };
  localparam int VREQ [NV] = '{1,1,1,2,2,2,3,3,4,4,4,5,5,6,6,7,7,8,8,11};

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {we,trap,sel} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_irq(input string req, input logic exp);
    checks++;
    if (ext_irq_valid !== exp) begin
      fails++;
      $display("FAIL %s: irq_valid actual %b expected %b", req, ext_irq_valid, exp);
    end
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_write = 0; req_num = '0;
    hv_mode = 0; emu_virt = 0; irq_disable = 0; ext_irq_req = 1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {gpr_we, emu_trap, slow_sel}, 6'b0);
    check_irq("R11", 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {req_valid, req_write, hv_mode, emu_virt, req_num} = VEC[i][19:6];
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VREQ[i], i), {gpr_we, emu_trap, slow_sel}, VEC[i][5:0]);
      // R10: exclusivity seen at the ports
      checks++;
      if (gpr_we && emu_trap) begin
        fails++;
        $display("FAIL R10: we=%b trap=%b expected not both", gpr_we, emu_trap);
      end
    end

    // R9: interrupt gating by state
    req_valid = 0;
    hv_mode = 0; irq_disable = 1; ext_irq_req = 1; @(negedge clk);
    check_irq("R9 user disable ignored", 1'b1);
    hv_mode = 1; irq_disable = 1; @(negedge clk);
    check_irq("R9 hv disabled", 1'b0);
    hv_mode = 1; irq_disable = 0; @(negedge clk);
    check_irq("R9 hv enabled", 1'b1);
    ext_irq_req = 0; hv_mode = 0; irq_disable = 0; @(negedge clk);
    check_irq("R9 none pending", 1'b0);

    // R11: trap followed by idle cycle clears outputs
    req_valid = 1; req_write = 0; req_num = 10'd4; hv_mode = 1; @(negedge clk);
    check("R1 read 4", {gpr_we, emu_trap, slow_sel}, 6'b010000);
    req_valid = 0; @(negedge clk);
    check("R11 idle after trap", {gpr_we, emu_trap, slow_sel}, 6'b0);

    // R11: reset mid-stream clears a pending read verdict
    req_valid = 1; req_num = 10'd268; @(negedge clk);
    rst = 1'b1; @(negedge clk);
    check("R11 reset clears", {gpr_we, emu_trap, slow_sel}, 6'b0);
    rst = 1'b0; req_valid = 0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #50000;
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule